// File: doc/BRIEF.md
# Interrupt Enable/Disable Mask and Status Register Set

This block is the interrupt front end of a serial port. The datapath raises event conditions, such as receive FIFO trigger, FIFO empty and full, line errors and receive timeout, on one input vector. A mask decides which of these events are latched into a sticky status register. A single interrupt line reports any latched status bit that is still enabled.

Software never writes the mask directly. Writing ones to an enable address sets mask bits, and writing ones to a disable address clears them. A read-only view returns the mask. Status bits are cleared by writing ones to the status address. A separate channel word shows the live FIFO levels whatever the mask holds, so polling code can see them with every interrupt disabled.

Every bit register shares one layout: bit 0 receive trigger, bit 1 receive empty, bit 2 receive full, bit 3 transmit empty, bit 4 transmit full, bit 5 overrun, bit 6 framing, bit 7 parity, bit 8 receive timeout. Bits 9 to 12 are spare sources. Word addresses are 0 enable, 1 disable, 2 mask, 3 status and 4 channel. Read data is registered and appears in the cycle after the read strobe, showing the state from before that clock edge.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset the mask and status registers are zero, irq_o is low and rd_data_o is zero.
- R2: A write to address 0 (enable) sets every mask bit whose write bit is 1 and leaves the other mask bits unchanged.
- R3: A write to address 1 (disable) clears every mask bit whose write bit is 1 and leaves the other mask bits unchanged.
- R4: A read of address 0 or 1 returns zero in the cycle after the read strobe.
- R5: Only the low NUM_SRC (13) data bits are used: write bits above them are ignored, and they read as zero from every address.
- R6: A bit of event_i sets the matching status bit at a clock edge only if that mask bit is 1 before the edge. A masked event leaves status unchanged.
- R7: Status bits are sticky. A write to address 3 clears the bits written as 1, and bits written as 0 keep their value.
- R8: When a clear of a status bit through address 3 falls in the same cycle as a new enabled event on that bit, the bit stays set.
- R9: irq_o is high exactly when some status bit is set and its mask bit is also set. Clearing a mask bit lowers irq_o without changing status.
- R10: A read of address 4 returns level_i for bits 0, 1, 3 and 4 (the CHAN_VIS default 0x001B), whatever the mask holds, and zero in every other bit.
- R11: Writes to address 2 (mask), address 4 (channel) or any unused address change neither mask nor status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data |
| event_i | input | NUM_SRC | Event conditions from the datapath |
| level_i | input | NUM_SRC | Live FIFO levels for the channel word |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: NUM_SRC of 13, DATA_W of 32 and the channel visibility mask 0x001B. With these values the 19 unused upper data bits can be driven with ones, which checks that they are ignored on write and read back as zero. The bench also drives all 13 source bits and level bits, so the channel filter is checked against live levels on bits that it must hide. Random cycles then mix events with enable, disable and clear writes on the same bits in the same cycle, which exercises both the clear-versus-event case and the rule that an event is gated by the mask value from before the edge.

// File: rtl/irq_regs_pkg.sv
`timescale 1ns/1ps
package irq_regs_pkg;

  typedef enum logic [2:0] {
    ADR_EN   = 3'd0,
    ADR_DIS  = 3'd1,
    ADR_MASK = 3'd2,
    ADR_STAT = 3'd3,
    ADR_CHAN = 3'd4
  } reg_addr_e;

  // shared bit layout
  localparam int unsigned BIT_RX_TRIG = 0;
  localparam int unsigned BIT_RX_EMPTY = 1;
  localparam int unsigned BIT_RX_FULL = 2;
  localparam int unsigned BIT_TX_EMPTY = 3;
  localparam int unsigned BIT_TX_FULL = 4;
  localparam int unsigned BIT_OVERRUN = 5;
  localparam int unsigned BIT_FRAMING = 6;
  localparam int unsigned BIT_PARITY = 7;
  localparam int unsigned BIT_RX_TOUT = 8;

endpackage

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank #(
  parameter int unsigned NUM_SRC = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] mask_o
);

  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q & ~clr_i) | set_i;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank #(
  parameter int unsigned NUM_SRC = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic st_q;
    // a new enabled event wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= 1'b0;
      else         st_q <= (st_q & ~clr_i[b]) | (event_i[b] & mask_i[b]);
    end
    assign status_o[b] = st_q;
  end

endmodule

// File: rtl/irq_read_mux.sv
`timescale 1ns/1ps
module irq_read_mux
  import irq_regs_pkg::*;
#(
  parameter int unsigned        NUM_SRC  = 13,
  parameter int unsigned        DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] CHAN_VIS = 13'h001B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               re_i,
  input  logic [2:0]         addr_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] level_i,
  output logic [DATA_W-1:0]  rd_data_o
);

  logic [NUM_SRC-1:0] sel;
  logic [DATA_W-1:0]  rd_q;

  always_comb begin
    case (addr_i)
      ADR_MASK: sel = mask_i;
      ADR_STAT: sel = status_i;
      ADR_CHAN: sel = level_i & CHAN_VIS;
      default:  sel = '0;  // enable/disable read as zero
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= DATA_W'(sel);
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned        NUM_SRC  = 13,
  parameter int unsigned        DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] CHAN_VIS = 13'h001B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [2:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [NUM_SRC-1:0] level_i,
  output logic               irq_o
);

  localparam int unsigned HI_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] wd_src;
  logic [HI_W-1:0]    unused_wd_hi;
  logic [NUM_SRC-1:0] en_set, dis_clr, st_clr;
  logic [NUM_SRC-1:0] mask_q, status_q;

  assign wd_src       = wdata_i[NUM_SRC-1:0];
  assign unused_wd_hi = wdata_i[DATA_W-1:NUM_SRC];

  assign en_set  = (we_i && addr_i == ADR_EN)   ? wd_src : '0;
  assign dis_clr = (we_i && addr_i == ADR_DIS)  ? wd_src : '0;
  assign st_clr  = (we_i && addr_i == ADR_STAT) ? wd_src : '0;

  irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (dis_clr),
    .mask_o (mask_q)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (event_i),
    .mask_i   (mask_q),
    .clr_i    (st_clr),
    .status_o (status_q)
  );

  irq_read_mux #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .CHAN_VIS (CHAN_VIS)
  ) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .re_i      (re_i),
    .addr_i    (addr_i),
    .mask_i    (mask_q),
    .status_i  (status_q),
    .level_i   (level_i),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = |(status_q & mask_q);

endmodule

// File: rtl/irq_ctrl_regs_chk.sv
`timescale 1ns/1ps
module irq_ctrl_regs_chk
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic               re_i,
  input logic [2:0]         addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [NUM_SRC-1:0] event_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] status_q
);

  logic [NUM_SRC-1:0] wd;
  logic [NUM_SRC-1:0] gated;
  logic               wr_en, wr_dis, wr_stat;

  assign wd      = wdata_i[NUM_SRC-1:0];
  assign gated   = event_i & mask_q;
  assign wr_en   = we_i && addr_i == ADR_EN;
  assign wr_dis  = we_i && addr_i == ADR_DIS;
  assign wr_stat = we_i && addr_i == ADR_STAT;

  // R2
  en_sets_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ((mask_q & $past(wd)) == $past(wd)));

  // R3
  dis_clears_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> ((mask_q & $past(wd)) == '0));

  // R4
  en_dis_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (addr_i == ADR_EN || addr_i == ADR_DIS)) |=> (rd_data_o == '0));

  // R6
  masked_event_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(gated)) == '0));

  // R7
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8
  event_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(gated)) == $past(gated)));

  // R9
  irq_needs_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q != '0 && mask_q != '0));

  // R11
  mask_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en || wr_dis) |=> $stable(mask_q));

  // R5
  rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> (rd_data_o[DATA_W-1:NUM_SRC] == '0));

endmodule

bind irq_ctrl_regs irq_ctrl_regs_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .re_i      (re_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rd_data_o (rd_data_o),
  .event_i   (event_i),
  .irq_o     (irq_o),
  .mask_q    (mask_q),
  .status_q  (status_q)
);

// File: tb/irq_ctrl_regs_test.sv
`timescale 1ns/1ps
module irq_ctrl_regs_test;

  localparam int unsigned N  = 13;
  localparam int unsigned DW = 32;
  localparam logic [N-1:0] VIS = 13'h001B;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0, re_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [N-1:0]  event_i = '0, level_i = '0;
  logic          irq_o;

  int checks = 0, errors = 0;
  logic [N-1:0]  m_mask = '0, m_stat = '0;
  logic [DW-1:0] m_rd = '0;

  always #5ns clk_i = ~clk_i;

  irq_ctrl_regs #(.NUM_SRC(N), .DATA_W(DW), .CHAN_VIS(VIS)) uut (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_model(input logic [2:0] a, input logic [N-1:0] lv);
    case (a)
      3'd2:    return DW'(m_mask);
      3'd3:    return DW'(m_stat);
      3'd4:    return DW'(lv & VIS);
      default: return '0;
    endcase
  endfunction

  // called at a negedge: drive, clock, update model, return at next negedge
  task automatic cyc(input logic we, input logic re, input logic [2:0] a,
                     input logic [DW-1:0] wd, input logic [N-1:0] ev);
    logic [N-1:0] clr, nstat;
    we_i = we; re_i = re; addr_i = a; wdata_i = wd; event_i = ev;
    @(posedge clk_i);
    if (re) m_rd = rd_model(a, level_i);
    clr   = (we && a == 3'd3) ? wd[N-1:0] : '0;
    nstat = (m_stat & ~clr) | (ev & m_mask);
    if (we && a == 3'd0) m_mask = m_mask | wd[N-1:0];
    if (we && a == 3'd1) m_mask = m_mask & ~wd[N-1:0];
    m_stat = nstat;
    @(negedge clk_i);
  endtask

  task automatic chk_out(input string tag);
    chk({tag, " irq"}, DW'(irq_o), DW'(|(m_stat & m_mask)));
    chk({tag, " rd"}, rd_data_o, m_rd);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input logic [N-1:0] ev);
    cyc(1'b1, 1'b0, a, d, ev);
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [DW-1:0] exp);
    cyc(1'b0, 1'b1, a, '0, '0);
    chk(tag, rd_data_o, exp);
    chk_out(tag);
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 reset irq", DW'(irq_o), '0);
    chk("R1 reset rd", rd_data_o, '0);
    rd(3'd2, "R1 mask", '0);
    rd(3'd3, "R1 status", '0);

    // R2
    wr(3'd0, 32'h0005, '0);
    rd(3'd2, "R2 enable", 32'h0005);
    wr(3'd0, 32'h0100, '0);
    rd(3'd2, "R2 zeros keep", 32'h0105);
    // R3
    wr(3'd1, 32'h0004, '0);
    rd(3'd2, "R3 disable", 32'h0101);
    // R4
    rd(3'd0, "R4 enable reads 0", '0);
    rd(3'd1, "R4 disable reads 0", '0);
    // R5
    wr(3'd0, 32'hFFFF_E000, '0);
    rd(3'd2, "R5 upper write ignored", 32'h0101);
    wr(3'd0, 32'hFFFF_FFFF, '0);
    rd(3'd2, "R5 upper reads 0", 32'h1FFF);
    wr(3'd1, 32'hFFFF_FFFF, '0);
    rd(3'd2, "R3 disable all", '0);

    // R6
    wr(3'd0, 32'h0001, '0);
    cyc(1'b0, 1'b0, 3'd0, '0, 13'h01FF);
    rd(3'd3, "R6 only masked latch", 32'h0001);
    chk("R9 irq high", DW'(irq_o), 1);
    // R7
    cyc(1'b0, 1'b0, 3'd0, '0, '0);
    wr(3'd3, 32'h0000, '0);
    rd(3'd3, "R7 sticky", 32'h0001);
    wr(3'd3, 32'h0001, '0);
    rd(3'd3, "R7 w1c", '0);
    chk("R9 irq low", DW'(irq_o), 0);
    // R8
    wr(3'd0, 32'h0100, '0);
    wr(3'd3, 32'h0100, 13'h0100);
    rd(3'd3, "R8 event beats clear", 32'h0100);
    // R9
    wr(3'd1, 32'h0100, '0);
    chk("R9 mask off lowers irq", DW'(irq_o), 0);
    rd(3'd3, "R9 status kept", 32'h0100);
    // R10
    wr(3'd1, 32'h1FFF, '0);
    level_i = 13'h1FFF;
    rd(3'd4, "R10 channel filter", 32'h001B);
    level_i = 13'h000A;
    rd(3'd4, "R10 channel live", 32'h000A);
    // R11
    wr(3'd2, 32'h1FFF, '0);
    wr(3'd4, 32'h1FFF, '0);
    wr(3'd7, 32'h1FFF, '0);
    rd(3'd2, "R11 mask unchanged", '0);
    rd(3'd3, "R11 status unchanged", 32'h0100);

    // random mix: R6 R7 R8 R9 against model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]    a;
      logic [DW-1:0] d;
      logic [N-1:0]  ev;
      a  = 3'($urandom_range(0, 5));
      d  = $urandom();
      ev = N'($urandom() & $urandom());
      level_i = N'($urandom());
      cyc(1'($urandom()), 1'($urandom()), a, d, ev);
      chk_out("R6 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule